// File: doc/BRIEF.md
# Atomic Reservation Tracker for Locked Loads and Conditional Stores

This block keeps the single atomic reservation of one processor. A locked load (32-bit or 64-bit) is checked for natural alignment. If it is aligned, the block records the address block it touched and arms a reservation flag. A conditional store is checked for alignment in the same way. It is forwarded to memory as a write request only when the flag is armed at the moment the store is accepted. Every conditional store, whether it writes or not, gets back the flag value (1 or 0) and leaves the flag cleared.

Writes from other agents are seen on a snoop port. A snooped write that falls in the same aligned block as the recorded address (16 bytes by default) drops the reservation. The memory write uses a valid/ready handshake. Each accepted request gets exactly one response, a one-cycle pulse carrying the result and an alignment-error bit. Load data, caches and the coherence protocol are handled elsewhere.

Top module: `atomic_resv_unit`

## Requirements
- R1: A locked load (`req_op`=0) raises `rsp_err`=1 in the response when the address is misaligned: `req_addr[1:0]`≠0 for a 32-bit access (`req_wide`=0), or `req_addr[2:0]`≠0 for a 64-bit access (`req_wide`=1). The response comes the cycle after acceptance.
- R2: Only an aligned locked load arms the reservation and records its block. A misaligned locked load leaves both the flag and the recorded block unchanged.
- R3: A conditional store (`req_op`=1) that is aligned and finds the flag armed issues exactly one memory write. Its response (`rsp_data`=1, `rsp_err`=0) is pulsed in the cycle after the write handshake (`mem_wr_valid` and `mem_wr_ready` both high).
- R4: A conditional store that finds the flag clear issues no write. It responds the cycle after acceptance with `rsp_data`=0 and `rsp_err`=0.
- R5: Every conditional store leaves the flag cleared, so a second store with no locked load in between fails. The store's address does not have to match the recorded one.
- R6: The write carries the request address unchanged. A 64-bit write has strobe 0xFF and data equal to the source. A 32-bit write places the source's low 32 bits in both halves of `mem_wr_data`, with strobe 0x0F when `req_addr[2]`=0 and 0xF0 when `req_addr[2]`=1.
- R7: A misaligned conditional store (same rule as R1) issues no write, responds the cycle after acceptance with `rsp_err`=1 and `rsp_data`=0, and leaves the flag cleared.
- R8: A snoop write whose address shares bits [AW-1:4] with the recorded block clears the flag. Any other snoop address has no effect. A snoop in the same cycle as an accepted locked load does not affect the new reservation. A snoop in the same cycle as an accepted conditional store does not change that store's outcome.
- R9: A synchronous active-low reset clears the flag, `mem_wr_valid` and `rsp_valid`, and leaves `req_ready`=1.
- R10: While a write waits for `mem_wr_ready`, its address, data and strobe are held, and `req_ready` stays low.
- R11: Every accepted request produces exactly one `rsp_valid` pulse of one cycle. A locked load responds with `rsp_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_op | input | 1 | 0 = locked load, 1 = conditional store |
| req_wide | input | 1 | 0 = 32-bit item, 1 = 64-bit item |
| req_addr | input | AW | Physical byte address |
| req_src | input | DW | Store source value |
| snoop_valid | input | 1 | Write by another agent observed |
| snoop_addr | input | AW | Address of the observed write |
| mem_wr_valid | output | 1 | Memory write request |
| mem_wr_ready | input | 1 | Memory accepts the write |
| mem_wr_addr | output | AW | Write address |
| mem_wr_data | output | DW | Write data |
| mem_wr_strb | output | DW/8 | Byte enables |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_data | output | DW | Flag value returned to a store (0 or 1), 0 for loads |
| rsp_err | output | 1 | Alignment exception |

## Verification
The bench sweeps every low-address offset of 0 to 15 for both widths of load and store. A design that checked the wrong number of address bits would flag legal 32-bit accesses at offset 4 or pass 64-bit accesses at offset 4, and one that armed on a faulting load would let the following store succeed. A sweep of snoop addresses across 64 bytes around the recorded block catches a design that compares too many or too few address bits, which would drop reservations from neighbouring blocks or keep them after a true conflict. Back-to-back stores, misaligned stores after an armed load, and stalled write handshakes expose designs that forget to clear the flag, that write despite an exception, or that let the write payload change while waiting.

// File: rtl/atomic_resv_pkg.sv
// Shared types and helpers for the atomic reservation unit.
// Assumes byte addressing with at most 64-bit items.
package atomic_resv_pkg;

    typedef enum logic {
        OP_LOAD_LOCKED = 1'b0,
        OP_STORE_COND  = 1'b1
    } resv_op_e;

    // Natural-alignment test on the three lowest address bits.
    function automatic logic is_misaligned(input logic wide, input logic [2:0] lsb);
        return wide ? (lsb != 3'd0) : (lsb[1:0] != 2'd0);
    endfunction

endpackage

// File: rtl/atomic_resv_align.sv
// Alignment checker: flags an access whose address is not a multiple of its size.
// Assumes only 4-byte and 8-byte items; purely combinational.
module atomic_resv_align #(
    parameter int AW = 32
) (
    input  logic          wide,
    input  logic [AW-1:0] addr,
    output logic          misaligned
);
    import atomic_resv_pkg::*;

    // Decode the low address bits against the access size.
    always_comb begin
        misaligned = is_misaligned(wide, addr[2:0]);
    end

endmodule

// File: rtl/atomic_resv_tracker.sv
// Reservation tracker: holds the lock flag and the recorded address block.
// Assumes arm and drop never coincide (they come from one accepted request).
// Arming wins over a same-cycle snoop; the snoop compares the old block only.
module atomic_resv_tracker #(
    parameter int AW        = 32,
    parameter int BLK_BYTES = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic [AW-1:0] arm_addr,
    input  logic          drop,
    input  logic          snoop_valid,
    input  logic [AW-1:0] snoop_addr,
    output logic          flag
);
    localparam int BLK_LSB = $clog2(BLK_BYTES);

    logic [AW-1:BLK_LSB] resv_blk;
    logic                snoop_hit;

    // Conflict test between an observed write and the recorded block.
    always_comb begin
        snoop_hit = snoop_valid && flag && (snoop_addr[AW-1:BLK_LSB] == resv_blk);
    end

    // Flag and block register: arm, then clear on store or conflict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag     <= 1'b0;
            resv_blk <= '0;
        end else if (arm) begin
            flag     <= 1'b1;
            resv_blk <= arm_addr[AW-1:BLK_LSB];
        end else if (drop || snoop_hit) begin
            flag     <= 1'b0;
        end
    end

endmodule

// File: rtl/atomic_resv_store_gate.sv
// Store gate and responder: launches the conditional write and pulses results.
// Assumes accept is only raised while no write is outstanding (busy low).
module atomic_resv_store_gate #(
    parameter int AW = 32,
    parameter int DW = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            accept,
    input  logic            is_store,
    input  logic            wide,
    input  logic            misaligned,
    input  logic            flag,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   src,
    input  logic            mem_wr_ready,
    output logic            busy,
    output logic            mem_wr_valid,
    output logic [AW-1:0]   mem_wr_addr,
    output logic [DW-1:0]   mem_wr_data,
    output logic [DW/8-1:0] mem_wr_strb,
    output logic            rsp_valid,
    output logic [DW-1:0]   rsp_data,
    output logic            rsp_err
);
    localparam int SB      = DW / 8;
    localparam int HB      = SB / 2;
    localparam int HW      = DW / 2;
    localparam int LANE_AB = $clog2(SB) - 1;

    logic            launch;
    logic [DW-1:0]   nxt_data;
    logic [SB-1:0]   nxt_strb;

    // Decide whether this accepted request becomes a memory write.
    always_comb begin
        launch = accept && is_store && !misaligned && flag;
    end

    // Place the payload on byte lanes according to size and address.
    always_comb begin
        if (wide) begin
            nxt_data = src;
            nxt_strb = '1;
        end else begin
            nxt_data = {src[HW-1:0], src[HW-1:0]};
            nxt_strb = addr[LANE_AB] ? {{HB{1'b1}}, {HB{1'b0}}}
                                     : {{HB{1'b0}}, {HB{1'b1}}};
        end
    end

    // Write-request register held until the handshake completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_wr_valid <= 1'b0;
            mem_wr_addr  <= '0;
            mem_wr_data  <= '0;
            mem_wr_strb  <= '0;
        end else if (mem_wr_valid && mem_wr_ready) begin
            mem_wr_valid <= 1'b0;
        end else if (launch) begin
            mem_wr_valid <= 1'b1;
            mem_wr_addr  <= addr;
            mem_wr_data  <= nxt_data;
            mem_wr_strb  <= nxt_strb;
        end
    end

    // Response pulse: success after handshake, otherwise right after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            rsp_err   <= 1'b0;
            if (mem_wr_valid && mem_wr_ready) begin
                rsp_valid <= 1'b1;
                rsp_data  <= {{(DW-1){1'b0}}, 1'b1};
            end else if (accept && !launch) begin
                rsp_valid <= 1'b1;
                rsp_err   <= misaligned;
            end
        end
    end

    assign busy = mem_wr_valid;

endmodule

// File: rtl/atomic_resv_unit.sv
// Top of the atomic reservation unit: one request port, a snoop port,
// a memory write port and a response pulse. Assumes one request at a time;
// requests stall (req_ready low) while a conditional write is outstanding.
module atomic_resv_unit #(
    parameter int AW        = 32,
    parameter int DW        = 64,
    parameter int BLK_BYTES = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic            req_op,
    input  logic            req_wide,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_src,
    input  logic            snoop_valid,
    input  logic [AW-1:0]   snoop_addr,
    output logic            mem_wr_valid,
    input  logic            mem_wr_ready,
    output logic [AW-1:0]   mem_wr_addr,
    output logic [DW-1:0]   mem_wr_data,
    output logic [DW/8-1:0] mem_wr_strb,
    output logic            rsp_valid,
    output logic [DW-1:0]   rsp_data,
    output logic            rsp_err
);
    import atomic_resv_pkg::*;

    logic     busy;
    logic     accept;
    logic     misaligned;
    logic     flag;
    logic     arm;
    logic     drop;
    resv_op_e op;

    // Request acceptance and decode of the operation.
    always_comb begin
        op        = resv_op_e'(req_op);
        req_ready = !busy;
        accept    = req_valid && !busy;
        arm       = accept && (op == OP_LOAD_LOCKED) && !misaligned;
        drop      = accept && (op == OP_STORE_COND);
    end

    atomic_resv_align #(.AW(AW)) u_align (
        .wide       (req_wide),
        .addr       (req_addr),
        .misaligned (misaligned)
    );

    atomic_resv_tracker #(.AW(AW), .BLK_BYTES(BLK_BYTES)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm         (arm),
        .arm_addr    (req_addr),
        .drop        (drop),
        .snoop_valid (snoop_valid),
        .snoop_addr  (snoop_addr),
        .flag        (flag)
    );

    atomic_resv_store_gate #(.AW(AW), .DW(DW)) u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept       (accept),
        .is_store     (op == OP_STORE_COND),
        .wide         (req_wide),
        .misaligned   (misaligned),
        .flag         (flag),
        .addr         (req_addr),
        .src          (req_src),
        .mem_wr_ready (mem_wr_ready),
        .busy         (busy),
        .mem_wr_valid (mem_wr_valid),
        .mem_wr_addr  (mem_wr_addr),
        .mem_wr_data  (mem_wr_data),
        .mem_wr_strb  (mem_wr_strb),
        .rsp_valid    (rsp_valid),
        .rsp_data     (rsp_data),
        .rsp_err      (rsp_err)
    );

endmodule

// File: rtl/atomic_resv_checker.sv
// Protocol checker for the atomic reservation unit, bound to its ports.
// Assumes the default 64-bit data width relation between strobe halves.
module atomic_resv_checker #(
    parameter int AW = 32,
    parameter int DW = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            req_op,
    input logic            req_wide,
    input logic [AW-1:0]   req_addr,
    input logic            mem_wr_valid,
    input logic            mem_wr_ready,
    input logic [AW-1:0]   mem_wr_addr,
    input logic [DW-1:0]   mem_wr_data,
    input logic [DW/8-1:0] mem_wr_strb,
    input logic            rsp_valid,
    input logic [DW-1:0]   rsp_data,
    input logic            rsp_err
);
    localparam int SB = DW / 8;

    // R1: a misaligned locked load is answered with an error next cycle.
    p_load_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_op &&
         (req_wide ? (req_addr[2:0] != 3'd0) : (req_addr[1:0] != 2'd0)))
        |=> (rsp_valid && rsp_err));

    // R3: a success response only follows a completed write handshake.
    p_success_hs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_data != '0) |-> $past(mem_wr_valid && mem_wr_ready));

    // R4: a failing response never coexists with an outstanding write.
    p_fail_nowrite_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_data == '0) |-> !mem_wr_valid);

    // R5: a write request only starts from an accepted conditional store.
    p_wr_origin_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_valid) |-> $past(req_valid && req_ready && req_op));

    // R6: the strobe covers either the full word or one half.
    p_strb_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |-> ($countones(mem_wr_strb) == SB || $countones(mem_wr_strb) == SB/2));

    // R7: an error response never reports success.
    p_err_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && rsp_data == '0));

    // R10: a stalled write holds its payload.
    p_wr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && !mem_wr_ready) |=>
        (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data) && $stable(mem_wr_strb)));

    // R10: no request is taken while a write is outstanding.
    p_busy_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |-> !req_ready);

endmodule

bind atomic_resv_unit atomic_resv_checker #(.AW(AW), .DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_op       (req_op),
    .req_wide     (req_wide),
    .req_addr     (req_addr),
    .mem_wr_valid (mem_wr_valid),
    .mem_wr_ready (mem_wr_ready),
    .mem_wr_addr  (mem_wr_addr),
    .mem_wr_data  (mem_wr_data),
    .mem_wr_strb  (mem_wr_strb),
    .rsp_valid    (rsp_valid),
    .rsp_data     (rsp_data),
    .rsp_err      (rsp_err)
);

// File: tb/atomic_resv_unit_bench.sv
// Self-checking bench: sweeps alignment offsets, snoop distances and store
// sequences against an arithmetic model of the reservation flag.
module atomic_resv_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_op = 1'b0;
    logic        req_wide = 1'b0;
    logic [31:0] req_addr = '0;
    logic [63:0] req_src = '0;
    logic        snoop_valid = 1'b0;
    logic [31:0] snoop_addr = '0;
    logic        mem_wr_valid;
    logic        mem_wr_ready = 1'b0;
    logic [31:0] mem_wr_addr;
    logic [63:0] mem_wr_data;
    logic [7:0]  mem_wr_strb;
    logic        rsp_valid;
    logic [63:0] rsp_data;
    logic        rsp_err;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    bit          m_flag = 1'b0;
    logic [27:0] m_blk = '0;

    always #5 clk = ~clk;

    atomic_resv_unit u_atomic_resv_unit (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_wide(req_wide), .req_addr(req_addr), .req_src(req_src),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
        .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .mem_wr_strb(mem_wr_strb),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit mis(input bit wide, input logic [31:0] a);
        return wide ? (a[2:0] != 0) : (a[1:0] != 0);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_flag = 1'b0;
    endtask

    // One request; captures write and response as seen at the ports.
    task automatic run_op(input bit op, input bit wide, input logic [31:0] a, input logic [63:0] src,
                          input int stall, input bit snp, input logic [31:0] sa,
                          output bit wrote, output logic [31:0] waddr, output logic [63:0] wdata,
                          output logic [7:0] wstrb, output bit rv, output logic [63:0] rd,
                          output bit re, output bit hold_ok);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_wide = wide; req_addr = a; req_src = src;
        snoop_valid = snp; snoop_addr = sa;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; snoop_valid = 1'b0;
        wrote = mem_wr_valid; waddr = mem_wr_addr; wdata = mem_wr_data; wstrb = mem_wr_strb;
        rv = rsp_valid; rd = rsp_data; re = rsp_err; hold_ok = 1'b1;
        if (wrote) begin
            for (int i = 0; i < stall; i++) begin
                if (!mem_wr_valid || req_ready || rsp_valid || mem_wr_addr != waddr ||
                    mem_wr_data != wdata || mem_wr_strb != wstrb) hold_ok = 1'b0;
                @(negedge clk);
            end
            mem_wr_ready = 1'b1;
            @(posedge clk);
            @(negedge clk);
            mem_wr_ready = 1'b0;
            if (mem_wr_valid || !req_ready) hold_ok = 1'b0;
            rv = rsp_valid; rd = rsp_data; re = rsp_err;
        end
        @(negedge clk);
        if (rsp_valid) hold_ok = 1'b0;
    endtask

    task automatic do_load(input bit wide, input logic [31:0] a, input bit snp, input logic [31:0] sa);
        bit wrote, rv, re, hok;
        logic [31:0] wa; logic [63:0] wd, rd; logic [7:0] ws;
        bit em = mis(wide, a);
        run_op(1'b0, wide, a, 64'h0, 0, snp, sa, wrote, wa, wd, ws, rv, rd, re, hok);
        chk(re == em, "R1 load alignment error", {63'd0, re}, {63'd0, em});
        chk(!wrote, "R2 load issues no write", {63'd0, wrote}, 64'd0);
        chk(rv && rd == 0 && hok, "R11 load single pulse data 0", rd, 64'd0);
        if (!em) begin
            m_flag = 1'b1;
            m_blk = a[31:4];
        end else if (snp && m_flag && sa[31:4] == m_blk) begin
            m_flag = 1'b0;
        end
    endtask

    task automatic do_store(input bit wide, input logic [31:0] a, input logic [63:0] src,
                            input int stall, input bit snp, input logic [31:0] sa, input string tag);
        bit wrote, rv, re, hok;
        logic [31:0] wa; logic [63:0] wd, rd; logic [7:0] ws;
        bit em = mis(wide, a);
        bit ok = !em && m_flag;
        logic [63:0] ed = wide ? src : {src[31:0], src[31:0]};
        logic [7:0]  es = wide ? 8'hFF : (a[2] ? 8'hF0 : 8'h0F);
        run_op(1'b1, wide, a, src, stall, snp, sa, wrote, wa, wd, ws, rv, rd, re, hok);
        chk(wrote == ok, {tag, " write issued only when armed and aligned"}, {63'd0, wrote}, {63'd0, ok});
        if (wrote && ok) begin
            chk(wa == a, "R6 write address", {32'd0, wa}, {32'd0, a});
            chk(wd == ed, "R6 write data lanes", wd, ed);
            chk(ws == es, "R6 write strobe", {56'd0, ws}, {56'd0, es});
            chk(hok, "R10 stalled write held and requests blocked", {63'd0, hok}, 64'd1);
        end
        chk(rv && rd == {63'd0, ok}, {tag, " store returns flag value"}, rd, {63'd0, ok});
        chk(re == em, "R7 store alignment error", {63'd0, re}, {63'd0, em});
        m_flag = 1'b0;
    endtask

    task automatic do_snoop(input logic [31:0] sa);
        @(negedge clk);
        snoop_valid = 1'b1; snoop_addr = sa;
        @(negedge clk);
        snoop_valid = 1'b0;
        if (m_flag && sa[31:4] == m_blk) m_flag = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state at the ports
        chk(!rsp_valid && !mem_wr_valid && req_ready, "R9 reset outputs",
            {61'd0, rsp_valid, mem_wr_valid, req_ready}, 64'd1);
        do_store(1'b1, 32'h40, 64'h1, 0, 1'b0, 0, "R9");

        // R1 R2 R6 R7: sweep load and store offsets for both widths
        for (int w = 0; w < 2; w++) begin
            for (int off = 0; off < 16; off++) begin
                do_load(w[0], 32'h1000 + off, 1'b0, 0);
                do_store(off[0] ^ w[0], 32'h2000 + off, 64'hA5A5_0000_0000_0000 + off * 64'h1_0101,
                         off % 3, 1'b0, 0, "R3");
            end
        end

        // R2: misaligned load keeps earlier reservation
        do_load(1'b1, 32'h3000, 1'b0, 0);
        do_load(1'b1, 32'h3004, 1'b0, 0);
        do_store(1'b1, 32'h3000, 64'h1122_3344_5566_7788, 1, 1'b0, 0, "R2");

        // R5: back-to-back stores
        do_load(1'b0, 32'h3100, 1'b0, 0);
        do_store(1'b0, 32'h3504, 64'hDEAD_BEEF_CAFE_F00D, 2, 1'b0, 0, "R5");
        do_store(1'b0, 32'h3100, 64'h5, 0, 1'b0, 0, "R5");
        do_store(1'b1, 32'h3108, 64'h6, 0, 1'b0, 0, "R4");

        // R7: misaligned store clears armed flag
        do_load(1'b1, 32'h3200, 1'b0, 0);
        do_store(1'b1, 32'h3202, 64'h7, 0, 1'b0, 0, "R7");
        do_store(1'b1, 32'h3200, 64'h8, 0, 1'b0, 0, "R7");

        // R8: snoop distance sweep around block 0x100..0x10F
        for (int d = 0; d < 64; d++) begin
            do_load(1'b1, 32'h108, 1'b0, 0);
            do_snoop(32'hE0 + d);
            do_store(1'b1, 32'h300, 64'h9 + d, d % 2, 1'b0, 0, "R8");
        end

        // R8: snoop coinciding with load or with store
        do_load(1'b1, 32'h140, 1'b1, 32'h148);
        do_store(1'b1, 32'h140, 64'hA, 0, 1'b0, 0, "R8");
        do_load(1'b0, 32'h150, 1'b0, 0);
        do_store(1'b0, 32'h150, 64'hB, 0, 1'b1, 32'h154, "R8");

        // R9: reset drops an armed reservation
        do_load(1'b1, 32'h400, 1'b0, 0);
        do_reset();
        do_store(1'b1, 32'h400, 64'hC, 0, 1'b0, 0, "R9");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule